// File: doc/BRIEF.md
# Tiled 16-bit Framebuffer Address Swizzler

This block turns a pixel coordinate in a 16-bit-per-pixel framebuffer into the byte address of that pixel in a tiled memory layout. Memory is divided into pages of 64x64 pixels, which is 8192 bytes each. A page holds 32 blocks of 16x8 pixels, and a block holds 128 halfwords. Inside a page the blocks are stored in a fixed, non-linear order, and inside a block the halfwords are also stored in a fixed, non-linear order. The address therefore comes from two nested permutations. It is not a row-stride product.

A drawing or display engine supplies four inputs: a base pointer in 2048-byte units, the buffer width in 64-pixel units, and the x and y coordinates. It receives a byte address. With the default build the result is registered, and a valid flag follows the input valid by one clock. A parameter selects a purely combinational variant instead.

Top module: `fb16_tile_addr`

## Requirements
- R1: The page base is base_ptr*2048 + (floor(px_y/64)*buf_width + floor(px_x/64))*8192.
- R2: The block row is (px_y mod 64)/8 and the block column is (px_x mod 64)/16. The permuted block index for rows 0..3 and columns 0..3 is {0,2,8,10}, {1,3,9,11}, {4,6,12,14}, {5,7,13,15}. Rows 4..7 use the same values plus 16. The block base is the page base plus the index times 256.
- R3: The halfword index depends on (px_y mod 8, px_x mod 16). For column 0..7 of row 0 it is 0,2,8,10,16,18,24,26, and columns 8..15 add 1 to those values. The row adds (row mod 2)*4 + (row/2)*32.
- R4: byte_addr equals the block base plus the halfword index times 2, so every valid address is even.
- R5: With base 0 and width 1, the 4096 pixels of page 0 map one-to-one onto the even addresses in [0, 8192).
- R6: Any base value is legal, including values that are not a whole page. Base 1 at the origin gives 2048, and no valid address lies below base_ptr*2048.
- R7: The arithmetic is 32 bits wide and does not wrap. With base 511, width 63 and pixel (4095,4095) the address is 34084862.
- R8: out_valid equals in_valid delayed by one clock. While rst_n is low, out_valid and byte_addr are 0.
- R9: In a cycle with in_valid low, byte_addr keeps its previous value.
- R10: Three fixed reference points hold: (63,63) with base 0 and width 1 gives 8190, (96,16) with base 0 and width 2 gives 11264, and (65,65) with base 3 and width 2 gives 30732.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate present this cycle |
| base_ptr | input | 9 | Buffer base, 2048-byte units |
| buf_width | input | 6 | Buffer width, 64-pixel units |
| px_x | input | 12 | Pixel column |
| px_y | input | 12 | Pixel row |
| out_valid | output | 1 | Address valid |
| byte_addr | output | 32 | Swizzled byte address |

## Verification
The bench builds the block with its defaults: the registered variant, 9-bit base, 6-bit width, 12-bit coordinates and a 32-bit address. The full coordinate range reaches the largest page-row product, which exercises the no-wrap corner. A complete sweep of page 0 checks the one-to-one mapping and therefore catches any swapped entry in either permutation. Pseudo-random gaps in in_valid exercise the hold behaviour and the valid latency alongside multi-page addressing.

// File: rtl/fb16_tile_pkg.sv
package fb16_tile_pkg;
  // Tile geometry, expressed as log2 values
  localparam int PAGE_LOG2   = 6;   // page is 64x64 pixels
  localparam int BLKW_LOG2   = 4;   // block is 16 pixels wide
  localparam int BLKH_LOG2   = 3;   // block is 8 pixels tall
  localparam int BASE_SHIFT  = 11;  // base pointer unit: 2048 bytes
  localparam int PAGE_SHIFT  = 13;  // page: 8192 bytes
  localparam int BLK_SHIFT   = 8;   // block: 256 bytes
  localparam int BIDX_W      = 5;   // 32 blocks per page
  localparam int HIDX_W      = 7;   // 128 halfwords per block
endpackage

// File: rtl/fb16_blk_perm.sv
module fb16_blk_perm
  import fb16_tile_pkg::*;
(
  input  logic [PAGE_LOG2-BLKH_LOG2-1:0] brow,
  input  logic [PAGE_LOG2-BLKW_LOG2-1:0] bcol,
  output logic [BIDX_W-1:0]              bidx
);
  // Block order inside a page, held as a small case ROM
  always_comb begin
    unique case ({brow, bcol})
      5'd0:  bidx = 5'd0;   5'd1:  bidx = 5'd2;   5'd2:  bidx = 5'd8;   5'd3:  bidx = 5'd10;
      5'd4:  bidx = 5'd1;   5'd5:  bidx = 5'd3;   5'd6:  bidx = 5'd9;   5'd7:  bidx = 5'd11;
      5'd8:  bidx = 5'd4;   5'd9:  bidx = 5'd6;   5'd10: bidx = 5'd12;  5'd11: bidx = 5'd14;
      5'd12: bidx = 5'd5;   5'd13: bidx = 5'd7;   5'd14: bidx = 5'd13;  5'd15: bidx = 5'd15;
      5'd16: bidx = 5'd16;  5'd17: bidx = 5'd18;  5'd18: bidx = 5'd24;  5'd19: bidx = 5'd26;
      5'd20: bidx = 5'd17;  5'd21: bidx = 5'd19;  5'd22: bidx = 5'd25;  5'd23: bidx = 5'd27;
      5'd24: bidx = 5'd20;  5'd25: bidx = 5'd22;  5'd26: bidx = 5'd28;  5'd27: bidx = 5'd30;
      5'd28: bidx = 5'd21;  5'd29: bidx = 5'd23;  5'd30: bidx = 5'd29;  default: bidx = 5'd31;
    endcase
  end
endmodule

// File: rtl/fb16_hw_perm.sv
module fb16_hw_perm
  import fb16_tile_pkg::*;
(
  input  logic [BLKH_LOG2-1:0] yb,
  input  logic [BLKW_LOG2-1:0] xb,
  output logic [HIDX_W-1:0]    hidx
);
  // The 128-entry halfword order is a pure bit permutation of the
  // in-block coordinate, so it is gathered instead of stored.
  always_comb begin
    hidx = {yb[2], yb[1], xb[2], xb[1], yb[0], xb[0], xb[3]};
  end
endmodule

// File: rtl/fb16_page_base.sv
module fb16_page_base
  import fb16_tile_pkg::*;
#(
  parameter int BASE_W  = 9,
  parameter int WIDTH_W = 6,
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 32
) (
  input  logic [BASE_W-1:0]  base_ptr,
  input  logic [WIDTH_W-1:0] buf_width,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  output logic [ADDR_W-1:0]  page_base
);
  localparam int PG_W = COORD_W - PAGE_LOG2;

  logic [ADDR_W-1:0] prow, pcol, pidx, base_bytes;

  always_comb begin
    prow       = ADDR_W'(px_y[COORD_W-1 -: PG_W]);
    pcol       = ADDR_W'(px_x[COORD_W-1 -: PG_W]);
    pidx       = prow * ADDR_W'(buf_width) + pcol;
    base_bytes = ADDR_W'(base_ptr) << BASE_SHIFT;
    page_base  = base_bytes + (pidx << PAGE_SHIFT);
  end
endmodule

// File: rtl/fb16_tile_addr.sv
module fb16_tile_addr
  import fb16_tile_pkg::*;
#(
  parameter int BASE_W     = 9,
  parameter int WIDTH_W    = 6,
  parameter int COORD_W    = 12,
  parameter int ADDR_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BASE_W-1:0]  base_ptr,
  input  logic [WIDTH_W-1:0] buf_width,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  byte_addr
);
  localparam int BROW_W = PAGE_LOG2 - BLKH_LOG2;
  localparam int BCOL_W = PAGE_LOG2 - BLKW_LOG2;

  logic [ADDR_W-1:0] page_base;
  logic [BIDX_W-1:0] bidx;
  logic [HIDX_W-1:0] hidx;
  logic [ADDR_W-1:0] addr_c;

  fb16_page_base #(
    .BASE_W (BASE_W),
    .WIDTH_W(WIDTH_W),
    .COORD_W(COORD_W),
    .ADDR_W (ADDR_W)
  ) u_page (
    .base_ptr (base_ptr),
    .buf_width(buf_width),
    .px_x     (px_x),
    .px_y     (px_y),
    .page_base(page_base)
  );

  fb16_blk_perm u_blk (
    .brow(px_y[PAGE_LOG2-1 -: BROW_W]),
    .bcol(px_x[PAGE_LOG2-1 -: BCOL_W]),
    .bidx(bidx)
  );

  fb16_hw_perm u_hw (
    .yb  (px_y[BLKH_LOG2-1:0]),
    .xb  (px_x[BLKW_LOG2-1:0]),
    .hidx(hidx)
  );

  always_comb begin
    addr_c = page_base
           + (ADDR_W'(bidx) << BLK_SHIFT)
           + (ADDR_W'(hidx) << 1);
  end

  generate
    if (REGISTERED) begin : g_reg
      logic              vld_d, vld_q;
      logic [ADDR_W-1:0] addr_d, addr_q;

      // next state: address loads only when a coordinate arrives
      always_comb begin
        vld_d  = in_valid;
        addr_d = in_valid ? addr_c : addr_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          addr_q <= '0;
        end else begin
          vld_q  <= vld_d;
          addr_q <= addr_d;
        end
      end

      assign out_valid = vld_q;
      assign byte_addr = addr_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign byte_addr = addr_c;
    end
  endgenerate
endmodule

// File: rtl/fb16_tile_addr_chk.sv
module fb16_tile_addr_chk #(
  parameter int BASE_W     = 9,
  parameter int ADDR_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BASE_W-1:0] base_ptr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] byte_addr
);
  generate
    if (REGISTERED) begin : g_props
      p_even_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !byte_addr[0]);

      p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

      p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(byte_addr));

      p_base_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (byte_addr >= (ADDR_W'($past(base_ptr)) << 11)));
    end
  endgenerate
endmodule

bind fb16_tile_addr fb16_tile_addr_chk #(
  .BASE_W    (BASE_W),
  .ADDR_W    (ADDR_W),
  .REGISTERED(REGISTERED)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .base_ptr (base_ptr),
  .out_valid(out_valid),
  .byte_addr(byte_addr)
);

// File: tb/fb16_tile_addr_tb.sv
`timescale 1ns/1ps
module fb16_tile_addr_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [8:0]  base_ptr;
  logic [5:0]  buf_width;
  logic [11:0] px_x;
  logic [11:0] px_y;
  logic        out_valid;
  logic [31:0] byte_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] exp_addr;

  fb16_tile_addr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_ptr(base_ptr), .buf_width(buf_width),
    .px_x(px_x), .px_y(px_y),
    .out_valid(out_valid), .byte_addr(byte_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference written from the requirements
  function automatic longint model(int b, int w, int x, int y);
    int row0[8]   = '{0, 2, 8, 10, 16, 18, 24, 26};
    int bpat[4]   = '{0, 2, 8, 10};
    int boff[4]   = '{0, 1, 4, 5};
    longint pg, blk, hw;
    int br, bc, r, c;
    pg  = longint'(b) * 2048 + (longint'(y / 64) * w + x / 64) * 8192;
    br  = (y % 64) / 8;
    bc  = (x % 64) / 16;
    blk = bpat[bc] + boff[br % 4] + ((br >= 4) ? 16 : 0);
    r   = y % 8;
    c   = x % 16;
    hw  = row0[c % 8] + ((c >= 8) ? 1 : 0) + (r % 2) * 4 + (r / 2) * 32;
    return pg + blk * 256 + hw * 2;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare at the following negedge
  task automatic step(bit v, int b, int w, int x, int y, string req);
    in_valid  = v;
    base_ptr  = 9'(b);
    buf_width = 6'(w);
    px_x      = 12'(x);
    px_y      = 12'(y);
    if (v) exp_addr = 32'(model(b, w, x, y));
    @(posedge clk);
    @(negedge clk);
    chk(req, "out_valid", longint'(out_valid), longint'(v));
    chk(req, "byte_addr", longint'(byte_addr), longint'(exp_addr));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit seen [4096];
    logic [31:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; base_ptr = '0; buf_width = '0;
    px_x = '0; px_y = '0; exp_addr = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "reset out_valid", longint'(out_valid), 0);
    chk("R8", "reset byte_addr", longint'(byte_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: fixed reference points, literal expectations
    step(1, 0, 1, 63, 63, "R10"); chk("R10", "ref a", longint'(byte_addr), 8190);
    step(1, 0, 2, 96, 16, "R10"); chk("R10", "ref b", longint'(byte_addr), 11264);
    step(1, 3, 2, 65, 65, "R10"); chk("R10", "ref c", longint'(byte_addr), 30732);
    // R6: sub-page base values
    step(1, 1, 1, 0, 0, "R6");    chk("R6", "base1", longint'(byte_addr), 2048);
    step(1, 3, 1, 0, 0, "R6");
    // R7: widest operands
    step(1, 511, 63, 4095, 4095, "R7");
    chk("R7", "max corner", longint'(byte_addr), 34084862);
    // R9: hold while idle
    step(0, 0, 1, 5, 5, "R9");
    chk("R9", "held", longint'(byte_addr), 34084862);
    step(0, 200, 7, 1000, 900, "R9");
    // R2: every block origin of page 0
    for (int by = 0; by < 8; by++)
      for (int bx = 0; bx < 4; bx++)
        step(1, 0, 1, bx * 16, by * 8, "R2");
    // R3: every pixel of the first block, one page over
    for (int yb = 0; yb < 8; yb++)
      for (int xb = 0; xb < 16; xb++)
        step(1, 0, 2, 64 + xb, yb, "R3");
    // R5 and R4: full page sweep, bijection and evenness
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 64; x++) begin
        step(1, 0, 1, x, y, "R5");
        chk("R4", "even", longint'(byte_addr[0]), 0);
        chk("R5", "in page", longint'(byte_addr < 32'd8192), 1);
        chk("R5", "unique", longint'(seen[byte_addr[12:1]]), 0);
        seen[byte_addr[12:1]] = 1'b1;
      end
    begin
      int holes = 0;
      for (int i = 0; i < 4096; i++) if (!seen[i]) holes++;
      chk("R5", "unreached slots", holes, 0);
    end
    // R1 / R8 / R9: pseudo-random mix with valid gaps
    lfsr = 32'hACE1_2467;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0] | lfsr[5], int'(lfsr[14:6]), int'(lfsr[20:15]),
           int'(lfsr[31:20]), int'({lfsr[3:0], lfsr[27:20]}), "R1");
    end
    // R8: reset in mid-run clears outputs
    step(1, 7, 3, 300, 200, "R8");
    rst_n = 1'b0;
    #1;
    chk("R8", "async clear valid", longint'(out_valid), 0);
    chk("R8", "async clear addr", longint'(byte_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_addr = '0;
    step(0, 0, 0, 0, 0, "R8");
    step(1, 2, 5, 130, 70, "R8");
    finish_run();
  end
endmodule